// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns characters taken from a show-ahead transmit FIFO into asynchronous serial frames on a single output line. A clock enable pulses at eight times the baud rate, and every bit on the line spans eight of those pulses. Because the baud rate is set only by the enable rate, the block covers 9600 to 3,200,000 baud without any change to its logic.

The frame shape is chosen by three format inputs. A 2-bit length code selects 5 to 8 data bits. A single bit selects one or two stop bits. A 3-bit code selects no parity, odd, even, forced-one or forced-zero parity. The format is captured when a frame begins, so the controlling logic may change it at any time without corrupting the character in flight.

An optional flow-control gate holds back new frames while the clear-to-send input is low. A copy of the line is provided for internal loopback routing.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `txd` is 1, `busy` is 0 and `fifo_pop` is 0.
- R2: A frame is a start bit of 0, then the data bits least significant first, then the parity bit if enabled, then the stop bits of value 1.
- R3: `word_len` selects the data bit count: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of `fifo_data` above the selected count are not sent.
- R4: `stop2` at 1 sends two stop bits, and at 0 sends one.
- R5: `par_mode` selects the parity bit: 4 makes the count of ones in data plus parity odd, 6 makes it even, 5 sends a constant 1, 7 sends a constant 0, and 0 to 3 send no parity bit.
- R6: Each bit occupies exactly eight `tick8` pulses. The line changes only in cycles where `tick8` is high, apart from the start of a frame.
- R7: `fifo_pop` pulses for one cycle when a frame starts, only while idle and `fifo_empty` is 0, and exactly once per character. The start bit appears on `txd` in the next cycle.
- R8: With `flow_en` at 1, no frame starts while `cts` is 0. `cts` is looked at only between frames, so a frame already started always completes.
- R9: `word_len`, `stop2` and `par_mode` are captured at frame start. Changing them mid-frame does not alter the current frame.
- R10: `busy` is 1 from the start bit through the end of the last stop bit. `tx_empty` is 1 exactly when `fifo_empty` is 1 and `busy` is 0.
- R11: `loop_txd` always equals `txd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick8 | input | 1 | Clock enable at eight times the baud rate |
| word_len | input | 2 | Data length code |
| stop2 | input | 1 | Two-stop-bit select |
| par_mode | input | 3 | Parity mode code |
| flow_en | input | 1 | Enables clear-to-send gating |
| cts | input | 1 | Clear to send, active high |
| fifo_empty | input | 1 | Transmit FIFO has no character |
| fifo_data | input | 8 | Head character of the FIFO, valid while not empty |
| fifo_pop | output | 1 | Removes the head character |
| txd | output | 1 | Serial output, idles high |
| loop_txd | output | 1 | Copy of the serial output for loopback |
| busy | output | 1 | A frame is on the line |
| tx_empty | output | 1 | FIFO empty and line idle |

## Verification
The assertions assume a show-ahead FIFO. Its head character is valid in the same cycle that `fifo_empty` is low, and it advances on the clock edge that samples `fifo_pop`. They also assume that `tick8` is a single-cycle pulse and that the inputs change only away from the clock edge. The bench models exactly such a FIFO and raises `tick8` for one cycle in every four. It changes the format, `cts` and FIFO contents only on falling edges, including the deliberate mid-frame changes that probe R8 and R9.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

    localparam int unsigned MAX_BITS = 8;
    localparam int unsigned MIN_BITS = 5;
    localparam int unsigned LEN_W    = $clog2(MAX_BITS);

    typedef enum logic [2:0] {
        PK_NONE,
        PK_ODD,
        PK_EVEN,
        PK_ONE,
        PK_ZERO
    } par_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_e;

    typedef struct packed {
        logic [LEN_W-1:0] last_idx;
        logic             two_stop;
        par_kind_e        par;
    } fmt_s;

endpackage

// File: rtl/sftx_cfg_decode.sv
module sftx_cfg_decode
    import sftx_pkg::*;
(
    input  logic [1:0] len_code,
    input  logic       stop_sel,
    input  logic [2:0] par_code,
    output fmt_s       fmt
);

    always_comb begin
        fmt.last_idx = LEN_W'(MIN_BITS - 1) + LEN_W'(len_code);
        fmt.two_stop = stop_sel;
        unique case (par_code)
            3'd4:    fmt.par = PK_ODD;
            3'd5:    fmt.par = PK_ONE;
            3'd6:    fmt.par = PK_EVEN;
            3'd7:    fmt.par = PK_ZERO;
            default: fmt.par = PK_NONE;
        endcase
    end

endmodule

// File: rtl/sftx_parity.sv
module sftx_parity
    import sftx_pkg::*;
(
    input  logic [MAX_BITS-1:0] dat,
    input  fmt_s                fmt,
    output logic                par_bit
);

    logic [MAX_BITS-1:0] used;
    logic                fold;

    for (genvar i = 0; i < MAX_BITS; i++) begin : g_mask
        assign used[i] = dat[i] & (LEN_W'(i) <= fmt.last_idx);
    end

    assign fold = ^used;

    always_comb begin
        unique case (fmt.par)
            PK_ODD:  par_bit = ~fold;
            PK_EVEN: par_bit = fold;
            PK_ONE:  par_bit = 1'b1;
            default: par_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/sftx_seq.sv
module sftx_seq
    import sftx_pkg::*;
#(
    parameter int unsigned OSR = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  fmt_s                fmt_in,
    input  logic                flow_en,
    input  logic                cts,
    input  logic                fifo_empty,
    input  logic [MAX_BITS-1:0] fifo_data,
    input  logic                par_bit,
    output logic                fifo_pop,
    output logic                txd,
    output logic                busy,
    output logic [MAX_BITS-1:0] dat_out,
    output fmt_s                fmt_out
);

    localparam int unsigned OS_W = (OSR > 1) ? $clog2(OSR) : 1;

    typedef struct packed {
        phase_e              phase;
        logic [OS_W-1:0]     tcnt;
        logic [LEN_W-1:0]    idx;
        logic                stop_b;
        logic [MAX_BITS-1:0] dat;
        fmt_s                fmt;
        logic                line;
    } seq_st_s;

    seq_st_s st_q, st_d;
    logic    pop_d;
    logic    bit_end;
    logic    may_start;
    logic [LEN_W-1:0] idx_nx;

    assign bit_end   = tick && (st_q.tcnt == OS_W'(OSR - 1));
    assign may_start = !fifo_empty && (!flow_en || cts);
    assign idx_nx    = st_q.idx + 1'b1;

    always_comb begin
        st_d  = st_q;
        pop_d = 1'b0;
        if (st_q.phase != PH_IDLE && tick) begin
            st_d.tcnt = bit_end ? '0 : st_q.tcnt + 1'b1;
        end
        unique case (st_q.phase)
            PH_IDLE: begin
                if (may_start) begin
                    pop_d       = 1'b1;
                    st_d.phase  = PH_START;
                    st_d.tcnt   = '0;
                    st_d.idx    = '0;
                    st_d.stop_b = 1'b0;
                    st_d.dat    = fifo_data;
                    st_d.fmt    = fmt_in;
                    st_d.line   = 1'b0;
                end
            end
            PH_START: begin
                if (bit_end) begin
                    st_d.phase = PH_DATA;
                    st_d.idx   = '0;
                    st_d.line  = st_q.dat[0];
                end
            end
            PH_DATA: begin
                if (bit_end) begin
                    if (st_q.idx == st_q.fmt.last_idx) begin
                        if (st_q.fmt.par != PK_NONE) begin
                            st_d.phase = PH_PAR;
                            st_d.line  = par_bit;
                        end else begin
                            st_d.phase = PH_STOP;
                            st_d.line  = 1'b1;
                        end
                    end else begin
                        st_d.idx  = idx_nx;
                        st_d.line = st_q.dat[idx_nx];
                    end
                end
            end
            PH_PAR: begin
                if (bit_end) begin
                    st_d.phase  = PH_STOP;
                    st_d.stop_b = 1'b0;
                    st_d.line   = 1'b1;
                end
            end
            PH_STOP: begin
                if (bit_end) begin
                    if (st_q.fmt.two_stop && !st_q.stop_b) begin
                        st_d.stop_b = 1'b1;
                    end else begin
                        st_d.phase = PH_IDLE;
                    end
                    st_d.line = 1'b1;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
                st_d.line  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase  <= PH_IDLE;
            st_q.tcnt   <= '0;
            st_q.idx    <= '0;
            st_q.stop_b <= 1'b0;
            st_q.dat    <= '0;
            st_q.fmt    <= '0;
            st_q.line   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fifo_pop = pop_d;
    assign txd      = st_q.line;
    assign busy     = (st_q.phase != PH_IDLE);
    assign dat_out  = st_q.dat;
    assign fmt_out  = st_q.fmt;

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

    assert_line_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && busy) |=> $stable(txd));

    assert_pop_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> (busy && !txd));

    assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    assert_cts_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_en && !cts && !busy) |=> !busy);

    assert_fmt_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fmt_out));

    assert_end_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick));

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import sftx_pkg::*;
#(
    parameter int unsigned OSR = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick8,
    input  logic [1:0]          word_len,
    input  logic                stop2,
    input  logic [2:0]          par_mode,
    input  logic                flow_en,
    input  logic                cts,
    input  logic                fifo_empty,
    input  logic [MAX_BITS-1:0] fifo_data,
    output logic                fifo_pop,
    output logic                txd,
    output logic                loop_txd,
    output logic                busy,
    output logic                tx_empty
);

    fmt_s                fmt_live;
    fmt_s                fmt_held;
    logic [MAX_BITS-1:0] dat_held;
    logic                par_bit;

    sftx_cfg_decode u_dec (
        .len_code (word_len),
        .stop_sel (stop2),
        .par_code (par_mode),
        .fmt      (fmt_live)
    );

    sftx_parity u_par (
        .dat     (dat_held),
        .fmt     (fmt_held),
        .par_bit (par_bit)
    );

    sftx_seq #(.OSR(OSR)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick8),
        .fmt_in     (fmt_live),
        .flow_en    (flow_en),
        .cts        (cts),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .par_bit    (par_bit),
        .fifo_pop   (fifo_pop),
        .txd        (txd),
        .busy       (busy),
        .dat_out    (dat_held),
        .fmt_out    (fmt_held)
    );

    assign loop_txd = txd;
    assign tx_empty = fifo_empty & ~busy;

endmodule

// File: tb/sim_serial_frame_tx.sv
module sim_serial_frame_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick8 = 1'b0;
    logic [1:0] word_len = 2'd3;
    logic       stop2 = 1'b0;
    logic [2:0] par_mode = 3'd0;
    logic       flow_en = 1'b0;
    logic       cts = 1'b0;
    logic       fifo_empty;
    logic [7:0] fifo_data;
    logic       fifo_pop, txd, loop_txd, busy, tx_empty;

    int vecs = 0;
    int fails = 0;
    int pops = 0;
    int tdiv = 0;
    logic [7:0] q [0:15];
    int wr = 0;
    int rd = 0;

    always #4 clk = ~clk;

    assign fifo_empty = (wr == rd);
    assign fifo_data  = q[rd[3:0]];

    always @(posedge clk) if (fifo_pop) begin
        rd   <= rd + 1;
        pops <= pops + 1;
    end

    always @(negedge clk) begin
        tdiv  = (tdiv + 1) % 4;
        tick8 = (tdiv == 0);
    end

    serial_frame_tx u0 (
        .clk(clk), .rst_n(rst_n), .tick8(tick8), .word_len(word_len),
        .stop2(stop2), .par_mode(par_mode), .flow_en(flow_en), .cts(cts),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
        .txd(txd), .loop_txd(loop_txd), .busy(busy), .tx_empty(tx_empty)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (!tick8);
        end
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        q[wr[3:0]] = b;
        wr++;
    endtask

    function automatic logic exp_par(input logic [7:0] b, input int nb, input logic [2:0] pm);
        logic x = 1'b0;
        for (int i = 0; i < nb; i++) x ^= b[i];
        case (pm)
            3'd4: return ~x;
            3'd5: return 1'b1;
            3'd6: return x;
            default: return 1'b0;
        endcase
    endfunction

    // action: 0 none, 1 drop cts after start (R8), 2 scramble format after start (R9)
    task automatic rx_frame(input logic [7:0] b, input int action);
        int nb = 5 + int'(word_len);
        logic two = stop2;
        logic [2:0] pm = par_mode;
        int guard = 0;
        int p0 = pops;
        while (txd !== 1'b0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk("R7 pop once per frame", pops, p0 + 1);
        chk("R10 busy at start", busy, 1);
        chk("R10 tx_empty low while busy", tx_empty, 0);
        if (action == 1) cts = 1'b0;
        if (action == 2) begin
            word_len = ~word_len;
            stop2    = ~stop2;
            par_mode = (pm == 3'd5) ? 3'd7 : 3'd5;
        end
        wait_ticks(4);
        chk("R2 start bit", txd, 0);
        chk("R11 loopback", loop_txd, txd);
        for (int i = 0; i < nb; i++) begin
            wait_ticks(8);
            chk(action == 2 ? "R9 data bit" : "R3 data bit", txd, b[i]);
            chk("R11 loopback", loop_txd, txd);
        end
        if (pm[2]) begin
            wait_ticks(8);
            chk("R5 parity bit", txd, exp_par(b, nb, pm));
        end
        wait_ticks(8);
        chk("R4 first stop", txd, 1);
        if (two) begin
            wait_ticks(8);
            chk("R4 second stop", txd, 1);
        end
        chk("R10 busy in last stop", busy, 1);
        wait_ticks(4);
        chk("R6 frame length in ticks", busy, 0);
        chk("R10 tx_empty after frame", tx_empty, fifo_empty);
        if (action == 2) begin
            word_len = ~word_len;
            stop2    = two;
            par_mode = pm;
        end
    endtask

    task automatic t_reset;
        chk("R1 txd idle", txd, 1);
        chk("R1 busy idle", busy, 0);
        chk("R1 no pop", fifo_pop, 0);
        chk("R10 tx_empty idle", tx_empty, 1);
        chk("R11 loopback idle", loop_txd, 1);
    endtask

    task automatic t_format(input logic [1:0] l, input logic s, input logic [2:0] p, input logic [7:0] b);
        word_len = l; stop2 = s; par_mode = p;
        push(b);
        rx_frame(b, 0);
    endtask

    task automatic t_flow;
        int p0;
        flow_en = 1'b1; cts = 1'b0;
        word_len = 2'd3; stop2 = 1'b0; par_mode = 3'd0;
        p0 = pops;
        push(8'h55); push(8'hC3);
        repeat (120) @(negedge clk);
        chk("R8 held: busy", busy, 0);
        chk("R8 held: line", txd, 1);
        chk("R8 held: no pop", pops, p0);
        chk("R10 tx_empty low with data", tx_empty, 0);
        cts = 1'b1;
        rx_frame(8'h55, 1);
        repeat (120) @(negedge clk);
        chk("R8 second held: busy", busy, 0);
        chk("R8 second held: pops", pops, p0 + 1);
        cts = 1'b1;
        rx_frame(8'hC3, 0);
        flow_en = 1'b0;
    endtask

    task automatic t_latch;
        word_len = 2'd1; stop2 = 1'b0; par_mode = 3'd6;
        push(8'h2D);
        rx_frame(8'h2D, 2);
    endtask

    task automatic t_back_to_back;
        int p0 = pops;
        word_len = 2'd3; stop2 = 1'b0; par_mode = 3'd4;
        push(8'h81); push(8'h7E);
        rx_frame(8'h81, 0);
        rx_frame(8'h7E, 0);
        chk("R7 two pops", pops, p0 + 2);
        chk("R10 tx_empty at end", tx_empty, 1);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1..all act=running exp=done");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_format(2'd3, 1'b0, 3'd0, 8'hA5);  // 8N1, R2 R3
        t_format(2'd0, 1'b1, 3'd6, 8'hF3);  // 5 bits even two stops, R3 R4 R5
        t_format(2'd1, 1'b0, 3'd4, 8'h2C);  // 6 bits odd, R5
        t_format(2'd2, 1'b0, 3'd5, 8'h00);  // 7 bits forced one, R5
        t_format(2'd3, 1'b1, 3'd7, 8'hFF);  // 8 bits forced zero, R5 R4
        t_format(2'd3, 1'b0, 3'd2, 8'h3C);  // code without parity, R5
        t_flow();
        t_latch();
        t_back_to_back();
        repeat (10) @(negedge clk);
        t_reset();
        finish_run();
    end

endmodule